// File: doc/BRIEF.md
# Stallable Multicycle Unit Wrapper

This block places a compute function whose latency varies from operation to operation inside a stage of a pipeline. When an operation starts, the wrapper captures the operands and the opcode. An external completion input decides the cycle in which the result counts as finished. A flush input forces that completion on every cycle, so the pipeline can be drained in a fixed number of cycles.

A stall input from downstream can refuse the finished result. The wrapper then keeps the result in a register and raises its own stall toward upstream until the result is taken. A squash input drops the operation in flight at any point. The arithmetic function here is a small stand-in with four operations; a real unit would take its place.

Control uses three states, each with its own meaning: the first cycle of an operation, in flight, and finished but held. When the parameter `HAS_STALL` is 0, the downstream stall input is ignored and the held state can never be reached.

Top module: `mc_unit_wrap`

## Requirements
- R1: After reset the control is in its first-cycle state. With `valid_i` low, `stall_o` is low, `res_vld_o` is low and `result_o` is zero.
- R2: Operands and opcode are captured only in the first-cycle state while `valid_i` is high. Changes on `a_i`, `b_i` and `op_i` in later cycles of the same operation have no effect on its result.
- R3: An operation completes in a cycle where `done_i` or `flush_i` is high. A flush alone therefore finishes an in-flight operation in that same cycle.
- R4: `stall_o` is high when `stall_i` is high, or when an operation is active and does not complete in that cycle. Otherwise it is low.
- R5: `result_o` carries the computed value and `res_vld_o` is high only when `stall_i` is low and the operation either completes in that cycle or is held. In every other cycle `result_o` is zero.
- R6: An active operation that does not complete moves to the in-flight state. It stays there, with `stall_o` high, until it completes.
- R7: If an operation completes while `stall_i` is high, the result is held unchanged. It is delivered in the first cycle with `stall_i` low, and the control then returns to its first-cycle state.
- R8: A squash blocks completion in that cycle and returns the control to the first-cycle state on the next cycle. The operation is discarded and no result appears for it.
- R9: Opcode encoding: 0 adds a+b, 1 subtracts a-b, 2 is bitwise AND, 3 is bitwise XOR. Results wrap to DATA_W bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | A new operation is offered |
| a_i | input | DATA_W | First operand |
| b_i | input | DATA_W | Second operand |
| op_i | input | 2 | Opcode |
| done_i | input | 1 | External completion choice |
| flush_i | input | 1 | Forces completion |
| squash_i | input | 1 | Aborts the operation in progress |
| stall_i | input | 1 | Downstream cannot accept a result |
| stall_o | output | 1 | Stall toward upstream stages |
| res_vld_o | output | 1 | `result_o` carries a delivered result |
| result_o | output | DATA_W | Result, zero when not delivered |

## Verification
On every cycle, assertions check the following:
- a delivered result never coincides with an upstream stall;
- a flush with a free downstream always delivers;
- a held result stays stable;
- squash, and the release of a held result, both lead back to the first-cycle state.

The bench scenarios cover the rest:
- operand capture against later changes on the inputs;
- arithmetic correctness at several latencies;
- zero output while results are refused;
- the loss of a squashed operation, including a squash of a held result.

// File: rtl/mcw_pkg.sv
package mcw_pkg;
  typedef enum logic [1:0] {
    ST_FIRST  = 2'd0,
    ST_FLIGHT = 2'd1,
    ST_HOLD   = 2'd2
  } mcw_state_e;

  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_AND = 2'd2,
    OP_XOR = 2'd3
  } mcw_op_e;
endpackage

// File: rtl/mcw_alu.sv
module mcw_alu #(
  parameter int DATA_W = 16
) (
  input  logic [1:0]        op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] y_o
);
  import mcw_pkg::*;

  always_comb begin
    unique case (mcw_op_e'(op_i))
      OP_ADD:  y_o = a_i + b_i;
      OP_SUB:  y_o = a_i - b_i;
      OP_AND:  y_o = a_i & b_i;
      default: y_o = a_i ^ b_i;
    endcase
  end
endmodule

// File: rtl/mcw_ctrl.sv
module mcw_ctrl #(
  parameter bit HAS_STALL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic stall_i,
  input  logic done_i,
  input  logic flush_i,
  input  logic squash_i,
  output logic first_o,
  output logic hold_o,
  output logic cmpl_o,
  output logic stall_o,
  output logic deliver_o
);
  import mcw_pkg::*;

  mcw_state_e state_q, state_d;
  logic ds_stall, busy;

  generate
    if (HAS_STALL) begin : g_stall
      assign ds_stall = stall_i;
    end else begin : g_nostall
      assign ds_stall = 1'b0;
    end
  endgenerate

  assign first_o   = (state_q == ST_FIRST);
  assign hold_o    = (state_q == ST_HOLD);
  assign busy      = (first_o & valid_i) | (state_q == ST_FLIGHT);
  // flush forces completion; squash forces it low
  assign cmpl_o    = busy & (done_i | flush_i) & ~squash_i;
  assign stall_o   = ds_stall | (busy & ~cmpl_o & ~squash_i);
  assign deliver_o = ~ds_stall & ~squash_i & (cmpl_o | hold_o);

  always_comb begin
    state_d = state_q;
    if (squash_i) begin
      state_d = ST_FIRST;
    end else if (hold_o) begin
      state_d = ds_stall ? ST_HOLD : ST_FIRST;
    end else if (busy) begin
      if (!cmpl_o)       state_d = ST_FLIGHT;
      else if (ds_stall) state_d = ST_HOLD;
      else               state_d = ST_FIRST;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_FIRST;
    else         state_q <= state_d;
  end

  assert_squash_first_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    squash_i |=> first_o);
  assert_hold_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_o && !stall_i && !squash_i) |=> first_o);
  assert_flight_stays_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !done_i && !flush_i && !squash_i) |=> (state_q == ST_FLIGHT));
endmodule

// File: rtl/mc_unit_wrap.sv
module mc_unit_wrap #(
  parameter int DATA_W    = 16,
  parameter bit HAS_STALL = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [1:0]        op_i,
  input  logic              done_i,
  input  logic              flush_i,
  input  logic              squash_i,
  input  logic              stall_i,
  output logic              stall_o,
  output logic              res_vld_o,
  output logic [DATA_W-1:0] result_o
);
  logic [DATA_W-1:0] a_q, b_q, a_sel, b_sel, alu_y, res_q;
  logic [1:0]        op_q, op_sel;
  logic              first, hold, cmpl, deliver;

  mcw_ctrl #(.HAS_STALL(HAS_STALL)) u_ctrl (
    .clk_i, .rst_ni, .valid_i, .stall_i, .done_i, .flush_i, .squash_i,
    .first_o(first), .hold_o(hold), .cmpl_o(cmpl), .stall_o(stall_o),
    .deliver_o(deliver)
  );

  // first cycle computes from live inputs, later cycles from captured copy
  assign a_sel  = first ? a_i  : a_q;
  assign b_sel  = first ? b_i  : b_q;
  assign op_sel = first ? op_i : op_q;

  mcw_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i(op_sel), .a_i(a_sel), .b_i(b_sel), .y_o(alu_y)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q  <= '0;
      b_q  <= '0;
      op_q <= '0;
    end else if (first && valid_i) begin
      a_q  <= a_i;
      b_q  <= b_i;
      op_q <= op_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   res_q <= '0;
    else if (cmpl) res_q <= alu_y;
  end

  assign res_vld_o = deliver;
  assign result_o  = deliver ? (hold ? res_q : alu_y) : '0;

  assert_no_deliver_in_stall_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_vld_o |-> !stall_o);
  assert_flush_delivers_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!first && !hold && flush_i && !squash_i && !stall_i) |-> res_vld_o);
  assert_hold_stable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold && $past(hold)) |-> $stable(res_q));
  assert_zero_when_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_vld_o |-> (result_o == '0));
endmodule

// File: tb/mc_unit_wrap_test.sv
module mc_unit_wrap_test;
  localparam int W = 16;
  localparam time PERIOD = 10ns;

  typedef struct packed {
    logic [1:0]   op;
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic [1:0]   lat;
    logic [1:0]   hold;
    logic         flush;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{2'd0, 16'h1234, 16'h1111, 2'd0, 2'd0, 1'b0},
    '{2'd1, 16'h0005, 16'h0007, 2'd1, 2'd0, 1'b0},
    '{2'd2, 16'hF0F0, 16'h3C3C, 2'd2, 2'd1, 1'b0},
    '{2'd3, 16'hAAAA, 16'h0FF0, 2'd3, 2'd2, 1'b0},
    '{2'd0, 16'hFFFF, 16'h0002, 2'd2, 2'd0, 1'b1},
    '{2'd1, 16'h8000, 16'h0001, 2'd0, 2'd3, 1'b0},
    '{2'd3, 16'h5A5A, 16'h5A5A, 2'd1, 2'd1, 1'b1},
    '{2'd2, 16'h1357, 16'hFFFF, 2'd3, 2'd0, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic valid = 0, done = 0, flush = 0, squash = 0, ds_stall = 0;
  logic [W-1:0] a = '0, b = '0;
  logic [1:0] op = '0;
  logic stall, res_vld;
  logic [W-1:0] result;
  int checks = 0, fails = 0;

  always #(PERIOD/2) clk = ~clk;

  mc_unit_wrap #(.DATA_W(W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .a_i(a), .b_i(b), .op_i(op),
    .done_i(done), .flush_i(flush), .squash_i(squash), .stall_i(ds_stall),
    .stall_o(stall), .res_vld_o(res_vld), .result_o(result)
  );

  function automatic logic [W-1:0] ref_fn(logic [1:0] o, logic [W-1:0] x, logic [W-1:0] y);
    case (o)
      2'd0: return x + y;
      2'd1: return x - y;
      2'd2: return x & y;
      default: return x ^ y;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    valid = 0; done = 0; flush = 0; squash = 0; ds_stall = 0;
  endtask

  task automatic run_op(input vec_t v);
    logic [W-1:0] exp;
    exp = ref_fn(v.op, v.a, v.b);
    @(negedge clk);
    for (int i = 0; i < int'(v.lat); i++) begin
      if (i == 0) begin valid = 1; a = v.a; b = v.b; op = v.op; end
      else begin valid = 0; a = ~v.a; b = v.a; op = ~v.op; end
      done = 0; flush = 0; ds_stall = 0;
      #1;
      check("R6 stall in flight", stall, 1);
      check("R5 no result in flight", res_vld, 0);
      @(negedge clk);
    end
    if (v.lat == 0) begin valid = 1; a = v.a; b = v.b; op = v.op; end
    else begin valid = 0; a = ~v.a; b = v.b + 16'h3; op = ~v.op; end  // R2 scramble
    done = !v.flush; flush = v.flush; ds_stall = (v.hold != 0);
    #1;
    if (v.hold != 0) begin
      check("R5 refused result zero", result, 0);
      check("R4 stall while refused", stall, 1);
      @(negedge clk);
      valid = 0; done = 0; flush = 0;
      for (int k = 1; k < int'(v.hold); k++) begin
        #1;
        check("R7 held output zero", result, 0);
        @(negedge clk);
      end
      ds_stall = 0;
      #1;
      check("R7 held result delivered", result, exp);
      check("R7 valid on release", res_vld, 1);
    end else begin
      check("R9 R3 R2 result", result, exp);
      check("R4 no stall on completion", stall, 0);
    end
    @(negedge clk);
    idle();
    #1;
    check("R7 back to first cycle", stall, 0);
  endtask

  initial begin
    #(PERIOD * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check("R1 reset stall", stall, 0);
    check("R1 reset valid", res_vld, 0);
    check("R1 reset result", result, 0);

    foreach (VECS[i]) run_op(VECS[i]);

    // R4: downstream stall passes through while idle
    @(negedge clk); ds_stall = 1; #1;
    check("R4 idle stall passthrough", stall, 1);
    @(negedge clk); idle();

    // R8: squash in flight
    valid = 1; a = 16'h0010; b = 16'h0020; op = 2'd0; #1;
    @(negedge clk); valid = 0; squash = 1; done = 1; #1;
    check("R8 no result on squash", res_vld, 0);
    @(negedge clk); squash = 0; done = 1; #1;
    check("R8 discarded op stays silent", res_vld, 0);
    check("R8 back to first, no stall", stall, 0);
    @(negedge clk); idle();

    // R8: squash a held result
    valid = 1; a = 16'h0003; b = 16'h0004; op = 2'd0; done = 1; ds_stall = 1;
    @(negedge clk); valid = 0; done = 0; squash = 1; #1;
    check("R8 squash in hold silent", res_vld, 0);
    @(negedge clk); squash = 0; ds_stall = 0; #1;
    check("R8 held result dropped", res_vld, 0);
    check("R8 held result output zero", result, 0);
    @(negedge clk); idle();

    // R3: flush alone completes in flight
    valid = 1; a = 16'h0100; b = 16'h0001; op = 2'd1;
    @(negedge clk); valid = 0; a = '0; flush = 1; #1;
    check("R3 flush completes", result, 16'h00FF);
    @(negedge clk); idle(); #1;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule